// File: doc/BRIEF.md
# Two-Tank Pump Interlock Controller

This block drives a single transfer pump that moves liquid from a source tank into a sink tank. Each tank carries two digital level switches: a low-mark switch that is high while the liquid is at or below the low mark, and a high-mark switch that is high while the liquid is at or above the high mark. Every raw switch passes through a two-flop synchroniser. The block then decodes each tank into one three-valued level and decides, one cycle later, whether the pump runs.

The pump runs only while the source has liquid to give and the sink has room to take it. The block provides a steady pump-enable level for the motor contactor. It also provides one-cycle start and stop strobes for equipment that acts on edges. A strobe appears only when the pump state really changes. If a tank reports both switches at once, the block treats it as a broken sensor. It latches a fault, stops the pump and keeps it stopped until reset.

Top module: `tank_pump_ctrl`

## Requirements
- R1: Each tank level appears on its 2-bit level output with this code: 2'b00 empty (low-mark switch only), 2'b01 ok (neither switch), 2'b10 full (high-mark switch only), 2'b11 reserved (both switches). The output follows a raw switch change after the second rising edge.
- R2: While reset is held and right after it, pump_en_o, on_cmd_o, off_cmd_o and fault_o are low, and both level outputs read empty (2'b00).
- R3: With the pump off and no fault, the pump turns on at the next edge when the source level is ok or full and the sink level is empty or ok.
- R4: With the pump on, the pump turns off at the next edge when the source level is empty or the sink level is full.
- R5: In every other case pump_en_o keeps its value. An off pump stays off while the source is empty or the sink is full, and an on pump stays on while neither holds.
- R6: on_cmd_o is high for exactly the one cycle in which pump_en_o has just risen. off_cmd_o is high for exactly the one cycle in which it has just fallen. The two are never high together.
- R7: No start strobe is issued while the pump is already on, and no stop strobe while it is already off. Every strobe coincides with a change of pump_en_o.
- R8: A reserved level on either tank sets fault_o at the same edge that the pump decision uses. The pump is then forced off, with a stop strobe if it was running. fault_o stays high for any later levels until reset.
- R9: A raw switch change is reflected on pump_en_o after exactly the third rising edge: two synchroniser stages plus the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_empty_i | input | 1 | Source tank low-mark switch, raw |
| src_full_i | input | 1 | Source tank high-mark switch, raw |
| snk_empty_i | input | 1 | Sink tank low-mark switch, raw |
| snk_full_i | input | 1 | Sink tank high-mark switch, raw |
| pump_en_o | output | 1 | Pump run level |
| on_cmd_o | output | 1 | One-cycle start strobe |
| off_cmd_o | output | 1 | One-cycle stop strobe |
| fault_o | output | 1 | Sticky sensor-fault flag |
| src_level_o | output | 2 | Decoded source level |
| snk_level_o | output | 2 | Decoded sink level |

## Verification
Assertions in the state machine check every cycle that the pump is off after a cycle with an empty source or a full sink, and that an off pump starts when the start condition holds. They also check that strobes and pump_en_o edges match one to one, that the two strobes are exclusive, and that the fault flag is sticky and keeps the pump off. Some properties can only be shown by the bench's scenarios, because they span the synchroniser or depend on raw switch patterns. These are the exact three-edge latency, the level encoding including the reserved code, and the rule that the reset value of the synchroniser cannot start the pump. The bench sweeps every ordered pair of legal tank-level combinations and then drives the fault paths with the pump both running and stopped.

// File: rtl/tank_pump_pkg.sv
package tank_pump_pkg;

  typedef enum logic [1:0] {
    LVL_EMPTY = 2'b00,
    LVL_OK    = 2'b01,
    LVL_FULL  = 2'b10,
    LVL_BAD   = 2'b11
  } level_e;

  localparam int unsigned NUM_TANKS = 2;
  localparam int unsigned TANK_SRC  = 0;
  localparam int unsigned TANK_SNK  = 1;
  localparam int unsigned SW_PER_TANK = 2;  // {full, empty}
  localparam int unsigned NUM_SW    = NUM_TANKS * SW_PER_TANK;

endpackage

// File: rtl/tp_sync.sv
module tp_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/tp_level_dec.sv
module tp_level_dec
  import tank_pump_pkg::*;
(
  input  logic   empty_i,
  input  logic   full_i,
  output level_e level_o
);

  always_comb begin
    unique case ({full_i, empty_i})
      2'b01:   level_o = LVL_EMPTY;
      2'b00:   level_o = LVL_OK;
      2'b10:   level_o = LVL_FULL;
      default: level_o = LVL_BAD;
    endcase
  end

endmodule

// File: rtl/tp_pump_fsm.sv
module tp_pump_fsm
  import tank_pump_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  level_e src_lvl_i,
  input  level_e snk_lvl_i,
  output logic   pump_en_o,
  output logic   on_cmd_o,
  output logic   off_cmd_o,
  output logic   fault_o
);

  logic pump_q, pump_d;
  logic fault_q, fault_d;
  logic on_q, off_q;
  logic lvl_bad, src_dry, snk_top;

  assign lvl_bad = (src_lvl_i == LVL_BAD) || (snk_lvl_i == LVL_BAD);
  assign src_dry = (src_lvl_i == LVL_EMPTY);
  assign snk_top = (snk_lvl_i == LVL_FULL);
  assign fault_d = fault_q | lvl_bad;

  always_comb begin
    pump_d = pump_q;
    if (fault_d)                        pump_d = 1'b0;
    else if (!pump_q && !src_dry && !snk_top) pump_d = 1'b1;
    else if (pump_q && (src_dry || snk_top))  pump_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pump_q  <= 1'b0;
      fault_q <= 1'b0;
      on_q    <= 1'b0;
      off_q   <= 1'b0;
    end else begin
      pump_q  <= pump_d;
      fault_q <= fault_d;
      on_q    <= pump_d & ~pump_q;
      off_q   <= pump_q & ~pump_d;
    end
  end

  assign pump_en_o = pump_q;
  assign on_cmd_o  = on_q;
  assign off_cmd_o = off_q;
  assign fault_o   = fault_q;

  AST_OFF_AFTER_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_lvl_i == LVL_EMPTY || snk_lvl_i == LVL_FULL) |=> !pump_en_o); // R4
  AST_ON_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pump_en_o && !fault_o && (src_lvl_i inside {LVL_OK, LVL_FULL})
     && (snk_lvl_i inside {LVL_EMPTY, LVL_OK})) |=> pump_en_o); // R3
  AST_CMD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(on_cmd_o && off_cmd_o)); // R6
  AST_CMD_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_cmd_o || off_cmd_o) |-> (pump_en_o != $past(pump_en_o))); // R7
  AST_EDGE_HAS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pump_en_o != $past(pump_en_o)) |-> (on_cmd_o == pump_en_o) && (off_cmd_o == !pump_en_o)); // R6
  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o); // R8
  AST_FAULT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !pump_en_o); // R8

endmodule

// File: rtl/tank_pump_ctrl.sv
module tank_pump_ctrl
  import tank_pump_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       src_empty_i,
  input  logic       src_full_i,
  input  logic       snk_empty_i,
  input  logic       snk_full_i,
  output logic       pump_en_o,
  output logic       on_cmd_o,
  output logic       off_cmd_o,
  output logic       fault_o,
  output logic [1:0] src_level_o,
  output logic [1:0] snk_level_o
);

  // per tank {full, empty}; reset shows both tanks empty so the pump cannot start
  localparam logic [NUM_SW-1:0] SW_RST = {NUM_TANKS{2'b01}};

  logic [NUM_SW-1:0] sw_raw, sw_sync;
  level_e            lvl [NUM_TANKS];

  assign sw_raw = {snk_full_i, snk_empty_i, src_full_i, src_empty_i};

  tp_sync #(
    .WIDTH  (NUM_SW),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SW_RST)
  ) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sw_raw),
    .q_o   (sw_sync)
  );

  for (genvar t = 0; t < NUM_TANKS; t++) begin : g_tank
    tp_level_dec dec_i (
      .empty_i(sw_sync[t*SW_PER_TANK]),
      .full_i (sw_sync[t*SW_PER_TANK+1]),
      .level_o(lvl[t])
    );
  end

  tp_pump_fsm fsm_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_lvl_i(lvl[TANK_SRC]),
    .snk_lvl_i(lvl[TANK_SNK]),
    .pump_en_o(pump_en_o),
    .on_cmd_o (on_cmd_o),
    .off_cmd_o(off_cmd_o),
    .fault_o  (fault_o)
  );

  assign src_level_o = lvl[TANK_SRC];
  assign snk_level_o = lvl[TANK_SNK];

endmodule

// File: tb/tank_pump_ctrl_tb_top.sv
`timescale 1ns/1ps
module tank_pump_ctrl_tb_top;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic src_empty_i = 1'b1, src_full_i = 1'b0, snk_empty_i = 1'b1, snk_full_i = 1'b0;
  logic pump_en_o, on_cmd_o, off_cmd_o, fault_o;
  logic [1:0] src_level_o, snk_level_o;

  int checks = 0;
  int errors = 0;
  logic m_pump = 1'b0;
  logic m_fault = 1'b0;

  always #2.5 clk_i = ~clk_i;

  tank_pump_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .src_empty_i(src_empty_i), .src_full_i(src_full_i),
    .snk_empty_i(snk_empty_i), .snk_full_i(snk_full_i),
    .pump_en_o(pump_en_o), .on_cmd_o(on_cmd_o), .off_cmd_o(off_cmd_o),
    .fault_o(fault_o), .src_level_o(src_level_o), .snk_level_o(snk_level_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] lvl(input logic e, input logic f);
    if (e && f) return 2'b11;
    if (f) return 2'b10;
    if (e) return 2'b00;
    return 2'b01;
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    src_empty_i = 1'b1; src_full_i = 1'b0; snk_empty_i = 1'b1; snk_full_i = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(pump_en_o == 0 && on_cmd_o == 0 && off_cmd_o == 0, "R2 outputs in reset",
        {pump_en_o, on_cmd_o, off_cmd_o}, 0);
    chk(fault_o == 0, "R2 fault in reset", fault_o, 0);
    rst_ni = 1'b1;
    m_pump = 1'b0; m_fault = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    chk(src_level_o == 2'b00 && snk_level_o == 2'b00, "R2 levels after reset",
        {src_level_o, snk_level_o}, 0);
    chk(pump_en_o == 0 && fault_o == 0, "R2 pump and fault after reset", {pump_en_o, fault_o}, 0);
  endtask

  // called at a negedge; drives raw switches and follows them through four edges
  task automatic apply(input logic se, input logic sf, input logic ke, input logic kf);
    logic [1:0] sl, kl;
    logic f_nxt, p_nxt;
    string tag;
    sl = lvl(se, sf);
    kl = lvl(ke, kf);
    src_empty_i = se; src_full_i = sf; snk_empty_i = ke; snk_full_i = kf;
    @(posedge clk_i); @(negedge clk_i);
    chk(pump_en_o == m_pump, "R9 pump before sync", pump_en_o, m_pump);
    chk(!on_cmd_o && !off_cmd_o, "R7 no strobe while settling", {on_cmd_o, off_cmd_o}, 0);
    @(posedge clk_i); @(negedge clk_i);
    chk(src_level_o == sl, "R1 source level", src_level_o, sl);
    chk(snk_level_o == kl, "R1 sink level", snk_level_o, kl);
    chk(pump_en_o == m_pump, "R9 pump two edges after change", pump_en_o, m_pump);
    f_nxt = m_fault | (sl == 2'b11) | (kl == 2'b11);
    if (f_nxt) p_nxt = 1'b0;
    else if (!m_pump) p_nxt = (sl == 2'b01 || sl == 2'b10) && (kl == 2'b00 || kl == 2'b01);
    else p_nxt = !(sl == 2'b00 || kl == 2'b10);
    if (p_nxt && !m_pump) tag = "R3 pump on";
    else if (!p_nxt && m_pump) tag = "R4 pump off";
    else tag = "R5 pump holds";
    if (f_nxt && !m_fault) tag = "R8 fault forces off";
    @(posedge clk_i); @(negedge clk_i);
    chk(pump_en_o == p_nxt, tag, pump_en_o, p_nxt);
    chk(on_cmd_o == (p_nxt && !m_pump), "R6 start strobe", on_cmd_o, p_nxt && !m_pump);
    chk(off_cmd_o == (!p_nxt && m_pump), "R6 stop strobe", off_cmd_o, !p_nxt && m_pump);
    chk(fault_o == f_nxt, "R8 fault flag", fault_o, f_nxt);
    m_pump = p_nxt;
    m_fault = f_nxt;
    @(posedge clk_i); @(negedge clk_i);
    chk(!on_cmd_o && !off_cmd_o, "R7 no redundant strobe", {on_cmd_o, off_cmd_o}, 0);
    chk(pump_en_o == m_pump, "R5 pump steady", pump_en_o, m_pump);
  endtask

  task automatic apply_lvl(input int s, input int k);
    apply(s == 0, s == 2, k == 0, k == 2);
  endtask

  initial begin
    do_reset();
    for (int a = 0; a < 9; a++) begin
      for (int b = 0; b < 9; b++) begin
        apply_lvl(a / 3, a % 3);
        apply_lvl(b / 3, b % 3);
      end
    end
    // R8: broken source sensor while running
    apply_lvl(1, 0);
    apply(1'b1, 1'b1, 1'b1, 1'b0);
    apply_lvl(1, 0);
    apply_lvl(2, 1);
    do_reset();
    chk(fault_o == 0, "R8 reset clears fault", fault_o, 0);
    // R8: broken sink sensor while stopped
    apply_lvl(0, 0);
    apply(1'b1, 1'b0, 1'b1, 1'b1);
    apply_lvl(2, 0);
    do_reset();
    apply_lvl(1, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule